// File: doc/BRIEF.md
# Pipelined Late-Write Synchronous SRAM

This block is a single-clock synchronous memory that takes a new operation on every clock edge. Reads and writes can follow each other in any order with no idle cycle between them. On each rising edge it registers a control word: a load/advance select, a read/write select, three chip enables, four active-low byte-write enables and the address. The write data for a given address comes two edges later. Read data appears two edges after its address edge, together with a valid flag.

On a load cycle a new address comes in from the pins, and the read/write select and chip enables take effect. On an advance cycle the block keeps the stored operation and steps the two low address bits in linear wrap order. The read/write select and chip enables are ignored on those cycles. An asynchronous active-low output enable blanks the read-data bus. It has no effect on the pipeline or on the valid flag.

Top module: `pl_sram`

## Requirements
- R1: During and right after reset, `rvalid` is 0, and no advance cycle before the first load performs any operation.
- R2: A load cycle (`ld_n`=0) with `rw`=1 and the device selected is a read. The stored word appears on `rdata` with `rvalid`=1 after the second rising edge following the address edge.
- R3: A load cycle with `rw`=0 and the device selected is a write. `wdata` is sampled on the second rising edge after the address edge. Byte lane n (bits 8n+7..8n) is written only when `be_n[n]` was 0 on the address edge. The other lanes keep their old value.
- R4: The device is selected only when, on the load cycle, `ce1_n`=0, `ce2_n`=0 and `ce3`=1. A deselected load, and every advance cycle after it, writes nothing and leaves `rvalid` at 0 in its output slot.
- R5: On an advance cycle (`ld_n`=1), `rw`, `ce1_n`, `ce2_n` and `ce3` are ignored. The operation type and selection of the last load continue. `be_n` is still sampled on every cycle.
- R6: Each advance cycle adds 1 modulo 4 to address bits [1:0]. The upper address bits stay unchanged. A load seeds bits [1:0] from `addr[1:0]`.
- R7: Reads and writes may alternate on every edge. A read whose address edge comes one edge after a write to the same address returns the newly written bytes.
- R8: With `oe_n`=1, `rdata` is 0 at once. With `oe_n`=0, `rdata` shows the last read word. `oe_n` has no effect on `rvalid` or on stored data.
- R9: On an advance cycle, `addr` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline |
| ld_n | input | 1 | 0 = load new address, 1 = advance burst |
| rw | input | 1 | 1 = read, 0 = write (load cycles only) |
| ce1_n | input | 1 | Chip enable, active low |
| ce2_n | input | 1 | Chip enable, active low |
| ce3 | input | 1 | Chip enable, active high |
| be_n | input | LANES | Byte-write enables, active low, one per lane |
| addr | input | AW | Word address |
| wdata | input | LANES*LW | Write data, two edges after its address |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | LANES*LW | Read data, 0 while `oe_n` is high |
| rvalid | output | 1 | Read data valid |

## Verification
The assertions assume that the control pins hold a known 0 or 1 at every sampled edge and that reset is applied before the first operation. They also assume that write data shows up on the edge it is expected, so no write slot ever carries undefined data. The stimulus drives every input at the falling edge with a defined value on every cycle. Before any read, it writes a defined word to every address, so each read returns known contents. Random cycles draw chip enables, load/advance and output enable with biased probabilities. Deselected bursts, long advance runs and blanked reads therefore all occur, alongside the directed cases.

// File: rtl/pl_sram.sv
module pl_sram #(
  parameter int AW    = 6,
  parameter int LANES = 4,
  parameter int LW    = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ld_n,
  input  logic                  rw,
  input  logic                  ce1_n,
  input  logic                  ce2_n,
  input  logic                  ce3,
  input  logic [LANES-1:0]      be_n,
  input  logic [AW-1:0]         addr,
  input  logic [LANES*LW-1:0]   wdata,
  input  logic                  oe_n,
  output logic [LANES*LW-1:0]   rdata,
  output logic                  rvalid
);
  localparam int DW    = LANES * LW;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  logic             s1_v, s1_rd;
  logic [AW-1:0]    s1_a;
  logic [LANES-1:0] s1_be;
  logic             s2_v, s2_rd;
  logic [AW-1:0]    s2_a;
  logic [LANES-1:0] s2_be;
  logic             rv_q;
  logic [DW-1:0]    rd_q;

  wire          ce_ok  = !ce1_n && !ce2_n && ce3;
  wire [1:0]    lo_nxt = s1_a[1:0] + 2'd1;
  wire [AW-1:0] nxt_a  = ld_n ? {s1_a[AW-1:2], lo_nxt} : addr;
  wire          nxt_rd = ld_n ? s1_rd : rw;
  wire          nxt_v  = ld_n ? s1_v  : ce_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v  <= 1'b0;
      s1_rd <= 1'b1;
      s1_a  <= '0;
      s1_be <= '1;
      s2_v  <= 1'b0;
      s2_rd <= 1'b1;
      s2_a  <= '0;
      s2_be <= '1;
      rv_q  <= 1'b0;
    end else begin
      s1_v  <= nxt_v;
      s1_rd <= nxt_rd;
      s1_a  <= nxt_a;
      s1_be <= be_n;
      s2_v  <= s1_v;
      s2_rd <= s1_rd;
      s2_a  <= s1_a;
      s2_be <= s1_be;
      rv_q  <= s2_v && s2_rd;
    end
  end

  always_ff @(posedge clk) begin
    if (s2_v && s2_rd) rd_q <= mem[s2_a];
    if (s2_v && !s2_rd) begin
      for (int i = 0; i < LANES; i++)
        if (!s2_be[i]) mem[s2_a][i*LW +: LW] <= wdata[i*LW +: LW];
    end
  end

  assign rdata  = oe_n ? '0 : rd_q;
  assign rvalid = rv_q;

  a_r2_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_n && rw && ce_ok) |=> ##2 rvalid);

  a_r4_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_n && !ce_ok) |=> ##2 !rvalid);

  a_r5_op_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ld_n |=> ($stable(s1_rd) && $stable(s1_v)));

  a_r6_upper_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ld_n |=> (s1_a[AW-1:2] == $past(s1_a[AW-1:2])));

  a_r6_low_step: assert property (@(posedge clk) disable iff (!rst_n)
    ld_n |=> (s1_a[1:0] == 2'($past(s1_a[1:0]) + 2'd1)));

  a_r8_oe_blank: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (rdata == '0));

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (!s2_v) |=> !rvalid);
endmodule

// File: tb/test_pl_sram.sv
module test_pl_sram;
  localparam int AW = 6, LANES = 4, LW = 8, DW = 32, DEPTH = 64;

  logic clk = 0, rst_n = 0;
  logic ld_n = 1, rw = 1, ce1_n = 0, ce2_n = 0, ce3 = 1, oe_n = 0;
  logic [LANES-1:0] be_n = '1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic rvalid;

  pl_sram #(.AW(AW), .LANES(LANES), .LW(LW)) i_pl_sram (
    .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .rw(rw), .ce1_n(ce1_n), .ce2_n(ce2_n),
    .ce3(ce3), .be_n(be_n), .addr(addr), .wdata(wdata), .oe_n(oe_n),
    .rdata(rdata), .rvalid(rvalid));

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [DW-1:0] mm [DEPTH];
  logic m1_v = 0, m1_rd = 1, m2_v = 0, m2_rd = 1;
  logic [AW-1:0] m1_a = 0, m2_a = 0;
  logic [LANES-1:0] m1_be = '1, m2_be = '1;
  logic [DW-1:0] last_rd = '0;

  function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] nw, logic [LANES-1:0] m);
    logic [DW-1:0] r = old;
    for (int i = 0; i < LANES; i++) if (!m[i]) r[i*LW +: LW] = nw[i*LW +: LW];
    return r;
  endfunction

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(string tag, logic l, logic r, logic c1, logic c2, logic c3,
                      logic [LANES-1:0] b, logic [AW-1:0] a, logic [DW-1:0] w, logic o);
    logic ev;
    @(negedge clk);
    ld_n = l; rw = r; ce1_n = c1; ce2_n = c2; ce3 = c3; be_n = b; addr = a; wdata = w; oe_n = o;
    @(posedge clk);
    ev = m2_v && m2_rd;
    if (ev) last_rd = mm[m2_a];
    if (m2_v && !m2_rd) mm[m2_a] = merge(mm[m2_a], w, m2_be);
    m2_v = m1_v; m2_rd = m1_rd; m2_a = m1_a; m2_be = m1_be;
    if (!l) begin m1_v = !c1 && !c2 && c3; m1_rd = r; m1_a = a; end
    else m1_a[1:0] = m1_a[1:0] + 2'd1;
    m1_be = b;
    #1;
    chk({tag, " rvalid"}, {31'b0, rvalid}, {31'b0, ev});
    if (o) chk({tag, " blank"}, rdata, '0);
    else if (ev) chk({tag, " rdata"}, rdata, last_rd);
  endtask

  task automatic wr(string tag, logic [AW-1:0] a, logic [LANES-1:0] b);
    step(tag, 0, 0, 0, 0, 1, b, a, $urandom, 0);
  endtask
  task automatic rd(string tag, logic [AW-1:0] a, logic o);
    step(tag, 0, 1, 0, 0, 1, '1, a, $urandom, o);
  endtask
  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) step(tag, 0, 1, 1, 0, 1, '1, $urandom, $urandom, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset", {31'b0, rvalid}, 32'b0);
    @(negedge clk) rst_n = 1;
    for (int i = 0; i < 4; i++) step("R1 adv-before-load", 1, 0, 0, 0, 1, 4'h0, 0, $urandom, 0);
    for (int i = 0; i < DEPTH; i++) wr("R3 fill", AW'(i), 4'h0);
    idle("R3 drain", 2);
    rd("R2 read", 6'd5, 0);
    rd("R2 read", 6'd63, 0);
    idle("R2 drain", 2);
    wr("R3 mask", 6'd9, 4'b1010);
    idle("R3 gap", 1);
    rd("R3 readback", 6'd9, 0);
    idle("R3 drain", 2);
    step("R4 ce1", 0, 0, 1, 0, 1, 4'h0, 6'd12, $urandom, 0);
    step("R4 adv", 1, 0, 0, 0, 1, 4'h0, 6'd0, $urandom, 0);
    step("R4 ce2", 0, 0, 0, 1, 1, 4'h0, 6'd13, $urandom, 0);
    step("R4 ce3", 0, 0, 0, 0, 0, 4'h0, 6'd14, $urandom, 0);
    step("R4 adv", 1, 1, 0, 0, 1, 4'h0, 6'd0, $urandom, 0);
    idle("R4 drain", 2);
    for (int i = 12; i < 16; i++) rd("R4 unchanged", AW'(i), 0);
    idle("R4 drain", 2);
    rd("R6 burst", 6'd22, 0);
    for (int i = 0; i < 3; i++) step("R5 R6 R9 adv", 1, 0, 1, 1, 0, 4'h0, $urandom, $urandom, 0);
    idle("R6 drain", 2);
    wr("R5 wburst", 6'd40, 4'h0);
    for (int i = 0; i < 5; i++) step("R5 R6 adv-wr", 1, 1, 1, 1, 0, 4'($urandom), $urandom, $urandom, 0);
    idle("R5 drain", 2);
    for (int i = 40; i < 44; i++) rd("R6 wrap check", AW'(i), 0);
    idle("R6 drain", 2);
    for (int i = 0; i < 8; i++) begin
      wr("R7 alt", 6'd30, 4'($urandom));
      rd("R7 alt", 6'd30, 0);
    end
    idle("R7 drain", 2);
    rd("R8 oe", 6'd30, 1);
    rd("R8 oe", 6'd31, 0);
    step("R8 oe", 0, 1, 1, 1, 1, '1, 0, 0, 1);
    step("R8 oe", 0, 1, 1, 1, 1, '1, 0, 0, 0);
    idle("R8 drain", 2);
    for (int i = 0; i < 4000; i++) begin
      logic desel = ($urandom % 10) == 0;
      step("R7 random", ($urandom % 3) == 0, $urandom, desel & $urandom, desel & $urandom,
           !desel | $urandom, 4'($urandom), $urandom, $urandom, ($urandom % 8) == 0);
    end
    idle("R7 drain", 3);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule